// File: doc/BRIEF.md
# Draw-State Group Register Bank

This block is the control-register bank a command processor uses to track up to 32 draw-state groups. Each group keeps a header word, a 64-bit base address, and a saved copy of the state-stream base (64-bit) and state-stream dword count. Software loads a group by writing three words in a row to a single load register: a header, then the low and then the high half of the base address. The header carries the group number, a dword count and a 3-bit mode mask. Loading a header marks the group live in a sticky bitmask and makes it the current selection.

A separate select register chooses which group is presented through the header and base view registers. The live state-stream registers are shared by all groups. Selecting a group first parks the live stream values in the group that was selected before, then fills the live registers from the newly chosen group. A registered read port returns any register one cycle after a read request.

Top module: `ds_group_bank`

## Requirements
- R1: After the active-low asynchronous reset, every register reads zero: all group entries, the live bitmask, the load phase, the selection and the previous-selection pointer.
- R2: Each write to the load register (address 0) steps the load phase 0, 1, 2, 0 (readable at address 11); writes to any other address leave the phase unchanged.
- R3: A phase-0 load word is a header: group number in bits 28:24, dword count in bits 15:0, mode mask in bits 22:20. Once the group is selected, address 9 reads the count and address 10 reads the mode mask of the viewed header.
- R4: A phase-0 load sets the bit of its group number in the live bitmask (address 2); bits already set stay set.
- R5: A phase-0 load makes its group number the selection (address 1) and leaves the header view, base view and live stream registers untouched.
- R6: Phase-1 and phase-2 loads store the low and then the high 32 bits of the base address of the group in the selection register at that time.
- R7: A write to the select register (address 1) uses the low 5 data bits as the group number and loads the header view (address 3, the full header word) and the base view (addresses 4 low, 5 high) from that group.
- R8: A select write stores the live stream base and count into the previously selected group, then reloads them from the chosen group, and records the chosen group as the previous selection; selecting the group already selected keeps the live values.
- R9: The live stream registers can be written directly: base low at address 6, base high at address 7, dword count at address 8.
- R10: A read request returns the addressed value one cycle later with rd_valid_o high and changes no state; writes to addresses 2, 3, 4, 5, 9, 10, 11 and 12 to 15 have no effect.
- R11: Unmapped addresses 12 to 15 read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| wr_addr_i | input | 4 | Write register address |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | 4 | Read register address |
| rd_valid_o | output | 1 | Read data valid, one cycle after request |
| rd_data_o | output | 32 | Read data |

## Verification
The hardest case to reach is the stream save-and-restore chain, because the saved copies inside each group are invisible until a later selection brings them back. The stimulus writes distinct live stream values, hops between three groups so each value is parked in one group and later restored from it, and re-selects the current group to check that the live values survive. A base write after a select that interrupts a load sequence checks that phases 1 and 2 follow the selection, not the header.

// File: rtl/ds_bank_pkg.sv
package ds_bank_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned HDR_IDX_LSB = 24;
  localparam int unsigned HDR_MODE_LSB = 20;
  localparam int unsigned HDR_MODE_W = 3;
  localparam int unsigned HDR_CNT_W = 16;

  typedef enum logic [3:0] {
    REG_SET      = 4'd0,
    REG_SEL      = 4'd1,
    REG_ACTIVE   = 4'd2,
    REG_HDR      = 4'd3,
    REG_BASE_LO  = 4'd4,
    REG_BASE_HI  = 4'd5,
    REG_SDS_LO   = 4'd6,
    REG_SDS_HI   = 4'd7,
    REG_SDS_DW   = 4'd8,
    REG_HDR_CNT  = 4'd9,
    REG_HDR_MODE = 4'd10,
    REG_PHASE    = 4'd11
  } reg_addr_e;

  typedef enum logic [1:0] {
    PH_HDR = 2'd0,
    PH_LO  = 2'd1,
    PH_HI  = 2'd2
  } set_phase_e;

  function automatic logic [HDR_CNT_W-1:0] hdr_cnt(input logic [DATA_W-1:0] w);
    return w[HDR_CNT_W-1:0];
  endfunction

  function automatic logic [HDR_MODE_W-1:0] hdr_mode(input logic [DATA_W-1:0] w);
    return w[HDR_MODE_LSB +: HDR_MODE_W];
  endfunction
endpackage

// File: rtl/ds_set_seq.sv
module ds_set_seq
  import ds_bank_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       set_we_i,
  output set_phase_e phase_o,
  output logic       hdr_we_o,
  output logic       lo_we_o,
  output logic       hi_we_o
);
  set_phase_e phase_q, phase_d;

  always_comb begin
    unique case (phase_q)
      PH_HDR:  phase_d = PH_LO;
      PH_LO:   phase_d = PH_HI;
      default: phase_d = PH_HDR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       phase_q <= PH_HDR;
    else if (set_we_i) phase_q <= phase_d;
  end

  assign hdr_we_o = set_we_i && (phase_q == PH_HDR);
  assign lo_we_o  = set_we_i && (phase_q == PH_LO);
  assign hi_we_o  = set_we_i && (phase_q == PH_HI);
  assign phase_o  = phase_q;
endmodule

// File: rtl/ds_group_store.sv
module ds_group_store
  import ds_bank_pkg::*;
#(
  parameter int unsigned N_GROUPS = 32,
  localparam int unsigned IDX_W = $clog2(N_GROUPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hdr_we_i,
  input  logic [IDX_W-1:0]  hdr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              lo_we_i,
  input  logic              hi_we_i,
  input  logic [IDX_W-1:0]  base_idx_i,
  input  logic              save_we_i,
  input  logic [IDX_W-1:0]  save_idx_i,
  input  logic [63:0]       save_base_i,
  input  logic [DATA_W-1:0] save_dw_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_hdr_o,
  output logic [63:0]       rd_base_o,
  output logic [63:0]       rd_sds_base_o,
  output logic [DATA_W-1:0] rd_sds_dw_o
);
  logic [N_GROUPS-1:0][DATA_W-1:0] hdr_flat;
  logic [N_GROUPS-1:0][63:0]       base_flat;
  logic [N_GROUPS-1:0][63:0]       sbase_flat;
  logic [N_GROUPS-1:0][DATA_W-1:0] sdw_flat;

  for (genvar g = 0; g < N_GROUPS; g++) begin : gen_grp
    logic [DATA_W-1:0] hdr_q;
    logic [63:0]       base_q;
    logic [63:0]       sbase_q;
    logic [DATA_W-1:0] sdw_q;
    logic              hit_hdr, hit_base, hit_save;

    assign hit_hdr  = hdr_we_i  && (hdr_idx_i  == IDX_W'(g));
    assign hit_base = base_idx_i == IDX_W'(g);
    assign hit_save = save_we_i && (save_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hdr_q   <= '0;
        base_q  <= '0;
        sbase_q <= '0;
        sdw_q   <= '0;
      end else begin
        if (hit_hdr)             hdr_q          <= wr_data_i;
        if (lo_we_i && hit_base) base_q[31:0]   <= wr_data_i;
        if (hi_we_i && hit_base) base_q[63:32]  <= wr_data_i;
        if (hit_save) begin
          sbase_q <= save_base_i;
          sdw_q   <= save_dw_i;
        end
      end
    end

    assign hdr_flat[g]   = hdr_q;
    assign base_flat[g]  = base_q;
    assign sbase_flat[g] = sbase_q;
    assign sdw_flat[g]   = sdw_q;
  end

  assign rd_hdr_o      = hdr_flat[rd_idx_i];
  assign rd_base_o     = base_flat[rd_idx_i];
  assign rd_sds_base_o = sbase_flat[rd_idx_i];
  assign rd_sds_dw_o   = sdw_flat[rd_idx_i];
endmodule

// File: rtl/ds_sel_ctrl.sv
module ds_sel_ctrl
  import ds_bank_pkg::*;
#(
  parameter int unsigned N_GROUPS = 32,
  localparam int unsigned IDX_W = $clog2(N_GROUPS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                hdr_we_i,
  input  logic [IDX_W-1:0]    hdr_idx_i,
  input  logic                sel_we_i,
  input  logic [IDX_W-1:0]    sel_idx_i,
  input  logic                sds_lo_we_i,
  input  logic                sds_hi_we_i,
  input  logic                sds_dw_we_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic [DATA_W-1:0]   st_hdr_i,
  input  logic [63:0]         st_base_i,
  input  logic [63:0]         st_sds_base_i,
  input  logic [DATA_W-1:0]   st_sds_dw_i,
  output logic [IDX_W-1:0]    sel_o,
  output logic [IDX_W-1:0]    prev_o,
  output logic [N_GROUPS-1:0] active_o,
  output logic [DATA_W-1:0]   hdr_view_o,
  output logic [63:0]         base_view_o,
  output logic [63:0]         sds_base_o,
  output logic [DATA_W-1:0]   sds_dw_o,
  output logic                save_we_o,
  output logic [IDX_W-1:0]    save_idx_o
);
  logic [IDX_W-1:0]    sel_q, prev_q;
  logic [N_GROUPS-1:0] active_q;
  logic [DATA_W-1:0]   hdr_v_q, sds_dw_q;
  logic [63:0]         base_v_q, sds_base_q;
  logic                same_grp;

  // reselecting the parked group must see the live values, not the stale copy
  assign same_grp = sel_idx_i == prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q      <= '0;
      prev_q     <= '0;
      active_q   <= '0;
      hdr_v_q    <= '0;
      base_v_q   <= '0;
      sds_base_q <= '0;
      sds_dw_q   <= '0;
    end else begin
      if (hdr_we_i) begin
        sel_q              <= hdr_idx_i;
        active_q[hdr_idx_i] <= 1'b1;
      end
      if (sel_we_i) begin
        sel_q    <= sel_idx_i;
        prev_q   <= sel_idx_i;
        hdr_v_q  <= st_hdr_i;
        base_v_q <= st_base_i;
        if (!same_grp) begin
          sds_base_q <= st_sds_base_i;
          sds_dw_q   <= st_sds_dw_i;
        end
      end
      if (sds_lo_we_i) sds_base_q[31:0]  <= wr_data_i;
      if (sds_hi_we_i) sds_base_q[63:32] <= wr_data_i;
      if (sds_dw_we_i) sds_dw_q          <= wr_data_i;
    end
  end

  assign save_we_o   = sel_we_i;
  assign save_idx_o  = prev_q;
  assign sel_o       = sel_q;
  assign prev_o      = prev_q;
  assign active_o    = active_q;
  assign hdr_view_o  = hdr_v_q;
  assign base_view_o = base_v_q;
  assign sds_base_o  = sds_base_q;
  assign sds_dw_o    = sds_dw_q;
endmodule

// File: rtl/ds_group_bank.sv
module ds_group_bank
  import ds_bank_pkg::*;
#(
  parameter int unsigned N_GROUPS = 32,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned IDX_W = $clog2(N_GROUPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic set_we, sel_we, sds_lo_we, sds_hi_we, sds_dw_we;
  logic hdr_we, lo_we, hi_we;
  set_phase_e phase;
  logic [IDX_W-1:0] hdr_idx, sel_idx, sel_q, prev_q, save_idx;
  logic [N_GROUPS-1:0] active_q;
  logic [DATA_W-1:0] st_hdr, st_sds_dw, hdr_view, sds_dw;
  logic [63:0] st_base, st_sds_base, base_view, sds_base, save_base;
  logic save_we;
  logic [DATA_W-1:0] rd_mux, rd_data_q;
  logic rd_valid_q;

  assign set_we    = wr_en_i && (wr_addr_i == ADDR_W'(REG_SET));
  assign sel_we    = wr_en_i && (wr_addr_i == ADDR_W'(REG_SEL));
  assign sds_lo_we = wr_en_i && (wr_addr_i == ADDR_W'(REG_SDS_LO));
  assign sds_hi_we = wr_en_i && (wr_addr_i == ADDR_W'(REG_SDS_HI));
  assign sds_dw_we = wr_en_i && (wr_addr_i == ADDR_W'(REG_SDS_DW));
  assign hdr_idx   = wr_data_i[HDR_IDX_LSB +: IDX_W];
  assign sel_idx   = wr_data_i[IDX_W-1:0];
  assign save_base = sds_base;

  ds_set_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_we_i (set_we),
    .phase_o  (phase),
    .hdr_we_o (hdr_we),
    .lo_we_o  (lo_we),
    .hi_we_o  (hi_we)
  );

  ds_group_store #(.N_GROUPS(N_GROUPS)) u_store (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .hdr_we_i      (hdr_we),
    .hdr_idx_i     (hdr_idx),
    .wr_data_i     (wr_data_i),
    .lo_we_i       (lo_we),
    .hi_we_i       (hi_we),
    .base_idx_i    (sel_q),
    .save_we_i     (save_we),
    .save_idx_i    (save_idx),
    .save_base_i   (save_base),
    .save_dw_i     (sds_dw),
    .rd_idx_i      (sel_idx),
    .rd_hdr_o      (st_hdr),
    .rd_base_o     (st_base),
    .rd_sds_base_o (st_sds_base),
    .rd_sds_dw_o   (st_sds_dw)
  );

  ds_sel_ctrl #(.N_GROUPS(N_GROUPS)) u_sel (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .hdr_we_i      (hdr_we),
    .hdr_idx_i     (hdr_idx),
    .sel_we_i      (sel_we),
    .sel_idx_i     (sel_idx),
    .sds_lo_we_i   (sds_lo_we),
    .sds_hi_we_i   (sds_hi_we),
    .sds_dw_we_i   (sds_dw_we),
    .wr_data_i     (wr_data_i),
    .st_hdr_i      (st_hdr),
    .st_base_i     (st_base),
    .st_sds_base_i (st_sds_base),
    .st_sds_dw_i   (st_sds_dw),
    .sel_o         (sel_q),
    .prev_o        (prev_q),
    .active_o      (active_q),
    .hdr_view_o    (hdr_view),
    .base_view_o   (base_view),
    .sds_base_o    (sds_base),
    .sds_dw_o      (sds_dw),
    .save_we_o     (save_we),
    .save_idx_o    (save_idx)
  );

  always_comb begin
    rd_mux = '0;
    unique case (rd_addr_i)
      ADDR_W'(REG_SEL):      rd_mux = DATA_W'(sel_q);
      ADDR_W'(REG_ACTIVE):   rd_mux = DATA_W'(active_q);
      ADDR_W'(REG_HDR):      rd_mux = hdr_view;
      ADDR_W'(REG_BASE_LO):  rd_mux = base_view[31:0];
      ADDR_W'(REG_BASE_HI):  rd_mux = base_view[63:32];
      ADDR_W'(REG_SDS_LO):   rd_mux = sds_base[31:0];
      ADDR_W'(REG_SDS_HI):   rd_mux = sds_base[63:32];
      ADDR_W'(REG_SDS_DW):   rd_mux = sds_dw;
      ADDR_W'(REG_HDR_CNT):  rd_mux = DATA_W'(hdr_cnt(hdr_view));
      ADDR_W'(REG_HDR_MODE): rd_mux = DATA_W'(hdr_mode(hdr_view));
      ADDR_W'(REG_PHASE):    rd_mux = DATA_W'(phase);
      default:               rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_en_i;
      if (rd_en_i) rd_data_q <= rd_mux;
    end
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_data_q;
endmodule

// File: rtl/ds_group_bank_chk.sv
module ds_group_bank_chk
  import ds_bank_pkg::*;
#(
  parameter int unsigned N_GROUPS = 32,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned IDX_W = $clog2(N_GROUPS)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_en_i,
  input logic [ADDR_W-1:0]   wr_addr_i,
  input logic [DATA_W-1:0]   wr_data_i,
  input logic                rd_en_i,
  input logic                rd_valid_o,
  input logic [1:0]          phase_i,
  input logic [IDX_W-1:0]    sel_i,
  input logic [IDX_W-1:0]    prev_i,
  input logic [N_GROUPS-1:0] active_i
);
  logic set_w, sel_w;
  assign set_w = wr_en_i && (wr_addr_i == ADDR_W'(REG_SET));
  assign sel_w = wr_en_i && (wr_addr_i == ADDR_W'(REG_SEL));

  assert_phase_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_w |=> phase_i == (($past(phase_i) == 2'd2) ? 2'd0 : $past(phase_i) + 2'd1));

  assert_phase_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_w |=> $stable(phase_i));

  assert_active_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((active_i & $past(active_i)) == $past(active_i)));

  assert_active_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_w && phase_i == 2'd0) |=> active_i[$past(wr_data_i[HDR_IDX_LSB +: IDX_W])]);

  assert_hdr_selects_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_w && phase_i == 2'd0) |=> sel_i == $past(wr_data_i[HDR_IDX_LSB +: IDX_W]));

  assert_sel_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_w |=> (sel_i == $past(wr_data_i[IDX_W-1:0])) && (prev_i == sel_i));

  assert_prev_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_w |=> $stable(prev_i));

  assert_rd_latency_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o);

  assert_rd_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rd_valid_o);

  assert_no_wr_no_change_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(sel_i) && $stable(active_i));
endmodule

bind ds_group_bank ds_group_bank_chk #(.N_GROUPS(N_GROUPS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .wr_data_i  (wr_data_i),
  .rd_en_i    (rd_en_i),
  .rd_valid_o (rd_valid_o),
  .phase_i    (phase),
  .sel_i      (sel_q),
  .prev_i     (prev_q),
  .active_i   (active_q)
);

// File: tb/ds_group_bank_bench.sv
module ds_group_bank_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        rd_en_i = 1'b0;
  logic [3:0]  rd_addr_i = '0;
  logic        rd_valid_o;
  logic [31:0] rd_data_o;

  int checks = 0;
  int errors = 0;
  logic  [31:0] exp_q[$];
  string tag_q[$];
  int    addr_q[$];

  // reference state
  logic [31:0] m_hdr [32];
  logic [63:0] m_base [32];
  logic [63:0] m_sb_arr [32];
  logic [31:0] m_sd_arr [32];
  logic [31:0] m_hv, m_sd, m_active;
  logic [63:0] m_bv, m_sb;
  logic [4:0]  m_sel, m_prev;
  int          m_phase;

  always #10 clk_i = ~clk_i;

  ds_group_bank u_ds_group_bank (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
  );

  function automatic logic [31:0] model_rd(input int a);
    case (a)
      1:  return 32'(m_sel);
      2:  return m_active;
      3:  return m_hv;
      4:  return m_bv[31:0];
      5:  return m_bv[63:32];
      6:  return m_sb[31:0];
      7:  return m_sb[63:32];
      8:  return m_sd;
      9:  return {16'd0, m_hv[15:0]};
      10: return {29'd0, m_hv[22:20]};
      11: return 32'(m_phase);
      default: return 32'd0;
    endcase
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    logic [4:0] idx;
    case (a)
      0: begin
        if (m_phase == 0) begin
          idx = d[28:24];
          m_hdr[idx] = d;
          m_active[idx] = 1'b1;
          m_sel = idx;
        end else if (m_phase == 1) m_base[m_sel][31:0] = d;
        else m_base[m_sel][63:32] = d;
        m_phase = (m_phase + 1) % 3;
      end
      1: begin
        idx = d[4:0];
        m_hv = m_hdr[idx];
        m_bv = m_base[idx];
        m_sb_arr[m_prev] = m_sb;
        m_sd_arr[m_prev] = m_sd;
        m_sb = m_sb_arr[idx];
        m_sd = m_sd_arr[idx];
        m_prev = idx;
        m_sel = idx;
      end
      6: m_sb[31:0] = d;
      7: m_sb[63:32] = d;
      8: m_sd = d;
      default: ;
    endcase
    wr_en_i = 1'b1; wr_addr_i = 4'(a); wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic chk(input int a, input string tag);
    exp_q.push_back(model_rd(a));
    tag_q.push_back(tag);
    addr_q.push_back(a);
    rd_en_i = 1'b1; rd_addr_i = 4'(a);
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  // monitor: one result per valid cycle
  always @(negedge clk_i) begin
    if (rst_ni && rd_valid_o) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R10 unexpected read data: actual %h expected none", rd_data_o);
      end else begin
        logic [31:0] e;
        string t;
        int ad;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        ad = addr_q.pop_front();
        if (rd_data_o !== e) begin
          errors++;
          $display("FAIL %s addr %0d: actual %h expected %h", t, ad, rd_data_o, e);
        end
      end
    end
  end

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog expired: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      m_hdr[i] = '0; m_base[i] = '0; m_sb_arr[i] = '0; m_sd_arr[i] = '0;
    end
    m_hv = '0; m_sd = '0; m_active = '0; m_bv = '0; m_sb = '0;
    m_sel = '0; m_prev = '0; m_phase = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1: reset values
    for (int a = 1; a < 12; a++) chk(a, "R1");
    // R11: unmapped
    for (int a = 12; a < 16; a++) chk(a, "R11");

    // header for group 5 with stray bits 31 and 23
    wr(0, 32'h85B0_1234);
    chk(1, "R5"); chk(2, "R4"); chk(11, "R2");
    chk(3, "R5"); chk(6, "R5");
    wr(0, 32'hDEAD_BEEF); chk(11, "R2");
    wr(0, 32'h0000_0012); chk(11, "R2");
    wr(1, 32'd5);
    chk(3, "R7"); chk(9, "R3"); chk(10, "R3");
    chk(4, "R6"); chk(5, "R6");

    // group 31 and group 0
    wr(0, 32'h1F70_ABCD); wr(0, 32'h1111_2222); wr(0, 32'h3333_4444);
    chk(2, "R4");
    wr(0, 32'h4000_0001); wr(0, 32'h0000_00AA); wr(0, 32'h0000_00BB);
    chk(2, "R4"); chk(1, "R5");

    // live stream registers
    wr(6, 32'hA0A0_0001); wr(7, 32'h0000_00B0); wr(8, 32'h0000_0040);
    chk(6, "R9"); chk(7, "R9"); chk(8, "R9");

    // park live in 5, load 31
    wr(1, 32'd31);
    chk(6, "R8"); chk(7, "R8"); chk(8, "R8");
    chk(3, "R7"); chk(10, "R3"); chk(4, "R6");
    wr(6, 32'h0000_5555); wr(8, 32'h0000_0077);
    // upper bits ignored: selects 5, parks into 31
    wr(1, 32'hFFFF_FFE5);
    chk(1, "R7"); chk(3, "R7");
    chk(6, "R8"); chk(7, "R8"); chk(8, "R8");
    // reselect same group keeps live values
    wr(8, 32'h0000_0099);
    wr(1, 32'd5);
    chk(8, "R8");
    wr(1, 32'd31);
    chk(6, "R8"); chk(8, "R8");
    wr(1, 32'd0);
    chk(4, "R7"); chk(5, "R7"); chk(8, "R8");

    // read-only and unmapped writes ignored
    wr(2, 32'd0); wr(3, 32'hFFFF_FFFF); wr(4, 32'h1234_5678); wr(5, 32'h1);
    wr(9, 32'h1); wr(10, 32'h7); wr(11, 32'h2); wr(13, 32'hFFFF_FFFF);
    chk(2, "R10"); chk(3, "R10"); chk(4, "R10"); chk(5, "R10");
    chk(11, "R10"); chk(1, "R10"); chk(13, "R10");

    // select between header and base words redirects base
    wr(0, 32'h0700_0000);
    wr(1, 32'd2);
    chk(11, "R2");
    wr(0, 32'hCAFE_0000); wr(0, 32'h0000_BEEF);
    chk(11, "R2"); chk(2, "R4");
    wr(1, 32'd2);
    chk(4, "R6"); chk(5, "R6");
    wr(1, 32'd7);
    chk(4, "R6"); chk(3, "R7");

    // reads have no side effects
    chk(1, "R10"); chk(1, "R10"); chk(6, "R10"); chk(11, "R10");

    repeat (4) @(negedge clk_i);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R10 missing read data: actual %0d pending expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule